// File: doc/BRIEF.md
# Privileged Segment Address Translator

This block turns a 32-bit virtual address into a physical address for a processor whose address space is split into five fixed segments. The segment is chosen by the top address bits. The privilege mode and an error-level flag decide whether the access is allowed and whether it is mapped. Segments with a fixed translation produce their physical address directly. Paged segments send the address out to an external page-table cache and wait for its answer. The page-table cache itself is outside this block.

Every request ends in exactly one response. The response gives either a physical address with read and write permission, or a fault. A fault comes with an exception kind that depends on the direction of the access, a refill flag that selects the fast refill handler, and new values for the three fault-capture registers. These are the faulting-address register, the page-table context register and the entry-high register. The caller supplies the current context and entry-high values with each request, and it writes the returned values back.

Top module: `seg_xlate_top`

## Requirements
- R1: Addresses below 0x8000_0000 pass through unchanged, with read and write permission, when `err_level` is 1. When `err_level` is 0 they go to the page-table lookup.
- R2: Addresses 0x8000_0000 to 0x9FFF_FFFF are allowed only in kernel mode (`req_mode` 2'b00). They translate to the address minus 0x8000_0000, with read and write permission.
- R3: Addresses 0xA000_0000 to 0xBFFF_FFFF are allowed only in kernel mode. They translate to the address minus 0xA000_0000, with read and write permission.
- R4: Addresses 0xC000_0000 to 0xDFFF_FFFF go to the lookup in supervisor mode (2'b01) or kernel mode. Addresses 0xE000_0000 and above go to the lookup only in kernel mode. Mode codes 2'b10 and 2'b11 both mean user.
- R5: An access that the mode does not permit faults with exception code 1 on a read or code 2 on a write. Any faulting response has both permissions 0 and a physical address of 0.
- R6: The lookup result code is 0 for hit, 1 for no-match, 2 for invalid and 3 for modify. No-match gives exception code 3 on a read or 4 on a write, with `rsp_refill` set. Invalid gives the same codes with `rsp_refill` clear. Modify gives code 5. Code 0 means no exception.
- R7: On a lookup hit, the physical address comes from `tlb_rsp_paddr`. Read permission is 1 and write permission equals `tlb_rsp_wr_ok`.
- R8: On any fault, `badaddr_out` holds the full address. `context_out` holds the context input with bits 22:4 replaced by address bits 31:13. `entry_hi_out` holds address bits 31:13 in bits 31:13, zeros in bits 12:8, and the input's bits 7:0.
- R9: When there is no fault, `badaddr_out` is 0 and `context_out` and `entry_hi_out` equal the inputs captured with the request.
- R10: An unmapped or refused request gets its single-cycle `rsp_valid` pulse one clock after it is accepted. A paged request raises `tlb_req_valid` in its request cycle and responds one clock after `tlb_rsp_valid`. Requests that arrive while a lookup is pending are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_mode | input | 2 | 00 kernel, 01 supervisor, 10/11 user |
| err_level | input | 1 | Error-level flag |
| entry_hi_in | input | 32 | Current entry-high value |
| context_in | input | 32 | Current context value |
| tlb_req_valid | output | 1 | Lookup request strobe |
| tlb_req_addr | output | 32 | Lookup address |
| tlb_rsp_valid | input | 1 | Lookup result strobe |
| tlb_rsp_kind | input | 2 | 0 hit, 1 no-match, 2 invalid, 3 modify |
| tlb_rsp_paddr | input | 32 | Physical address on hit |
| tlb_rsp_wr_ok | input | 1 | Page writable on hit |
| rsp_valid | output | 1 | Response strobe |
| rsp_paddr | output | 32 | Physical address |
| rsp_perm_rd | output | 1 | Read permitted |
| rsp_perm_wr | output | 1 | Write permitted |
| rsp_fault | output | 1 | Access faulted |
| rsp_exc | output | 3 | Exception code (see R5, R6) |
| rsp_refill | output | 1 | Fault is a lookup no-match |
| badaddr_out | output | 32 | New faulting-address value |
| context_out | output | 32 | New context value |
| entry_hi_out | output | 32 | New entry-high value |

## Verification
The hardest case to reach is a new request arriving while a page lookup is still outstanding. The block must drop that request and still report the first one, using the address, direction and register values that were captured with it. The bench holds a lookup open for several cycles and, in the middle of the wait, drives an unmapped kernel request with different register inputs. It then checks that no response or lookup strobe follows that request, and that the eventual response carries only the first request's values.

// File: rtl/segx_pkg.sv
package segx_pkg;
  localparam int VA_W    = 32;
  localparam int ASID_W  = 8;
  localparam int VPN_LO  = 13;
  localparam int CTX_LO  = 4;
  localparam int CTX_HI  = CTX_LO + (VA_W - VPN_LO) - 1;

  localparam logic [VA_W-1:0] KSEG0_BASE = 32'h8000_0000;
  localparam logic [VA_W-1:0] KSEG1_BASE = 32'hA000_0000;
  localparam logic [VA_W-1:0] SSEG_BASE  = 32'hC000_0000;
  localparam logic [VA_W-1:0] KSEG3_BASE = 32'hE000_0000;

  typedef enum logic [1:0] {
    MODE_KERN = 2'b00, MODE_SUP = 2'b01, MODE_USER = 2'b10, MODE_USER_ALT = 2'b11
  } priv_mode_e;

  typedef enum logic [1:0] {
    LK_HIT = 2'd0, LK_NOMATCH = 2'd1, LK_INVALID = 2'd2, LK_MODIFY = 2'd3
  } lookup_res_e;

  typedef enum logic [2:0] {
    EXC_NONE = 3'd0, EXC_ADDR_LD = 3'd1, EXC_ADDR_ST = 3'd2,
    EXC_TLB_LD = 3'd3, EXC_TLB_ST = 3'd4, EXC_TLB_MOD = 3'd5
  } exc_kind_e;

  typedef enum logic [1:0] {
    ROUTE_DIRECT = 2'd0, ROUTE_LOOKUP = 2'd1, ROUTE_REFUSE = 2'd2
  } route_e;

  // Context update: page-number bits of the address land in the middle field
  function automatic logic [VA_W-1:0] ctx_merge(input logic [VA_W-1:0] ctx,
                                                 input logic [VA_W-1:0] va);
    logic [VA_W-1:0] r;
    r = ctx;
    r[CTX_HI:CTX_LO] = va[VA_W-1:VPN_LO];
    return r;
  endfunction

  // Entry-high update: address page number above, ASID kept below, gap zeroed
  function automatic logic [VA_W-1:0] ehi_merge(input logic [VA_W-1:0] ehi,
                                                 input logic [VA_W-1:0] va);
    logic [VA_W-1:0] r;
    r = '0;
    r[ASID_W-1:0] = ehi[ASID_W-1:0];
    r[VA_W-1:VPN_LO] = va[VA_W-1:VPN_LO];
    return r;
  endfunction
endpackage

// File: rtl/seg_decode.sv
module seg_decode
  import segx_pkg::*;
(
  input  logic [VA_W-1:0] va,
  input  logic [1:0]      mode,
  input  logic            err_level,
  output route_e          route,
  output logic [VA_W-1:0] direct_pa
);
  logic in_kern, in_sup;
  assign in_kern = (priv_mode_e'(mode) == MODE_KERN);
  assign in_sup  = (priv_mode_e'(mode) == MODE_SUP);

  always_comb begin
    route     = ROUTE_REFUSE;
    direct_pa = '0;
    if (va < KSEG0_BASE) begin
      route     = err_level ? ROUTE_DIRECT : ROUTE_LOOKUP;
      direct_pa = va;
    end else if (va < KSEG1_BASE) begin
      if (in_kern) begin
        route     = ROUTE_DIRECT;
        direct_pa = va - KSEG0_BASE;
      end
    end else if (va < SSEG_BASE) begin
      if (in_kern) begin
        route     = ROUTE_DIRECT;
        direct_pa = va - KSEG1_BASE;
      end
    end else if (va < KSEG3_BASE) begin
      if (in_kern || in_sup) route = ROUTE_LOOKUP;
    end else begin
      if (in_kern) route = ROUTE_LOOKUP;
    end
  end
endmodule

// File: rtl/fault_fmt.sv
module fault_fmt
  import segx_pkg::*;
(
  input  logic            refused,
  input  logic            from_lookup,
  input  logic [1:0]      lk_kind,
  input  logic            is_write,
  input  logic [VA_W-1:0] va,
  input  logic [VA_W-1:0] ehi_in,
  input  logic [VA_W-1:0] ctx_in,
  output logic            fault,
  output exc_kind_e       exc,
  output logic            refill,
  output logic [VA_W-1:0] bad_va,
  output logic [VA_W-1:0] ctx_out,
  output logic [VA_W-1:0] ehi_out
);
  always_comb begin
    exc    = EXC_NONE;
    refill = 1'b0;
    if (refused) begin
      exc = is_write ? EXC_ADDR_ST : EXC_ADDR_LD;
    end else if (from_lookup) begin
      unique case (lookup_res_e'(lk_kind))
        LK_HIT:     exc = EXC_NONE;
        LK_NOMATCH: begin
          exc    = is_write ? EXC_TLB_ST : EXC_TLB_LD;
          refill = 1'b1;
        end
        LK_INVALID: exc = is_write ? EXC_TLB_ST : EXC_TLB_LD;
        LK_MODIFY:  exc = EXC_TLB_MOD;
      endcase
    end
  end

  assign fault   = (exc != EXC_NONE);
  assign bad_va  = fault ? va : '0;
  assign ctx_out = fault ? ctx_merge(ctx_in, va) : ctx_in;
  assign ehi_out = fault ? ehi_merge(ehi_in, va) : ehi_in;
endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
  import segx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  input  logic        req_write,
  input  logic [1:0]  req_mode,
  input  logic        err_level,
  input  logic [31:0] entry_hi_in,
  input  logic [31:0] context_in,
  output logic        tlb_req_valid,
  output logic [31:0] tlb_req_addr,
  input  logic        tlb_rsp_valid,
  input  logic [1:0]  tlb_rsp_kind,
  input  logic [31:0] tlb_rsp_paddr,
  input  logic        tlb_rsp_wr_ok,
  output logic        rsp_valid,
  output logic [31:0] rsp_paddr,
  output logic        rsp_perm_rd,
  output logic        rsp_perm_wr,
  output logic        rsp_fault,
  output logic [2:0]  rsp_exc,
  output logic        rsp_refill,
  output logic [31:0] badaddr_out,
  output logic [31:0] context_out,
  output logic [31:0] entry_hi_out
);
  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} xl_state_e;

  xl_state_e       st;
  logic [VA_W-1:0] h_addr, h_ehi, h_ctx;
  logic            h_write;

  route_e          route;
  logic [VA_W-1:0] direct_pa;

  // Named events for the assertions
  logic accept, issue_lookup, finish_direct, finish_lookup, finish;

  seg_decode u_dec (
    .va        (req_addr),
    .mode      (req_mode),
    .err_level (err_level),
    .route     (route),
    .direct_pa (direct_pa)
  );

  assign accept        = req_valid && (st == ST_IDLE);
  assign issue_lookup  = accept && (route == ROUTE_LOOKUP);
  assign finish_direct = accept && (route != ROUTE_LOOKUP);
  assign finish_lookup = (st == ST_WAIT) && tlb_rsp_valid;
  assign finish        = finish_direct || finish_lookup;

  assign tlb_req_valid = issue_lookup;
  assign tlb_req_addr  = req_addr;

  // Source select for the fault formatter: live request or held request
  logic [VA_W-1:0] f_va, f_ehi, f_ctx;
  logic            f_write;
  assign f_va    = finish_lookup ? h_addr  : req_addr;
  assign f_ehi   = finish_lookup ? h_ehi   : entry_hi_in;
  assign f_ctx   = finish_lookup ? h_ctx   : context_in;
  assign f_write = finish_lookup ? h_write : req_write;

  logic            f_fault, f_refill;
  exc_kind_e       f_exc;
  logic [VA_W-1:0] f_bad, f_ctx_new, f_ehi_new;

  fault_fmt u_fmt (
    .refused     (finish_direct && (route == ROUTE_REFUSE)),
    .from_lookup (finish_lookup),
    .lk_kind     (tlb_rsp_kind),
    .is_write    (f_write),
    .va          (f_va),
    .ehi_in      (f_ehi),
    .ctx_in      (f_ctx),
    .fault       (f_fault),
    .exc         (f_exc),
    .refill      (f_refill),
    .bad_va      (f_bad),
    .ctx_out     (f_ctx_new),
    .ehi_out     (f_ehi_new)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      h_addr  <= '0;
      h_ehi   <= '0;
      h_ctx   <= '0;
      h_write <= 1'b0;
    end else begin
      if (issue_lookup) begin
        st      <= ST_WAIT;
        h_addr  <= req_addr;
        h_ehi   <= entry_hi_in;
        h_ctx   <= context_in;
        h_write <= req_write;
      end else if (finish_lookup) begin
        st <= ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_paddr    <= '0;
      rsp_perm_rd  <= 1'b0;
      rsp_perm_wr  <= 1'b0;
      rsp_fault    <= 1'b0;
      rsp_exc      <= EXC_NONE;
      rsp_refill   <= 1'b0;
      badaddr_out  <= '0;
      context_out  <= '0;
      entry_hi_out <= '0;
    end else begin
      rsp_valid <= finish;
      if (finish) begin
        rsp_fault    <= f_fault;
        rsp_exc      <= f_exc;
        rsp_refill   <= f_refill;
        badaddr_out  <= f_bad;
        context_out  <= f_ctx_new;
        entry_hi_out <= f_ehi_new;
        rsp_perm_rd  <= !f_fault;
        if (f_fault)            rsp_paddr <= '0;
        else if (finish_lookup) rsp_paddr <= tlb_rsp_paddr;
        else                    rsp_paddr <= direct_pa;
        rsp_perm_wr  <= !f_fault && (finish_lookup ? tlb_rsp_wr_ok : 1'b1);
      end
    end
  end

  // ---------------- assertions ----------------
  assert_fault_noperm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> !rsp_perm_rd && !rsp_perm_wr && rsp_paddr == '0);

  assert_exc_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault == (rsp_exc != 3'd0)));

  assert_refill_tlb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_refill |-> (rsp_exc == 3'd3 || rsp_exc == 3'd4));

  assert_ehi_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> entry_hi_out[12:8] == 5'd0);

  assert_map_waits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_req_valid |=> !rsp_valid);

  assert_wait_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT) && !tlb_rsp_valid |=> !rsp_valid && $stable(h_addr));
endmodule

// File: tb/tb_seg_xlate_top.sv
`timescale 1ns/1ps
module tb_seg_xlate_top;
  localparam real CLK_NS = 8.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_mode = 2'b00;
  logic        err_level = 1'b0;
  logic [31:0] entry_hi_in = '0;
  logic [31:0] context_in = '0;
  logic        tlb_req_valid;
  logic [31:0] tlb_req_addr;
  logic        tlb_rsp_valid = 1'b0;
  logic [1:0]  tlb_rsp_kind = 2'd0;
  logic [31:0] tlb_rsp_paddr = '0;
  logic        tlb_rsp_wr_ok = 1'b0;
  logic        rsp_valid, rsp_perm_rd, rsp_perm_wr, rsp_fault, rsp_refill;
  logic [31:0] rsp_paddr, badaddr_out, context_out, entry_hi_out;
  logic [2:0]  rsp_exc;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  seg_xlate_top dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_mode(req_mode), .err_level(err_level),
    .entry_hi_in(entry_hi_in), .context_in(context_in),
    .tlb_req_valid(tlb_req_valid), .tlb_req_addr(tlb_req_addr),
    .tlb_rsp_valid(tlb_rsp_valid), .tlb_rsp_kind(tlb_rsp_kind),
    .tlb_rsp_paddr(tlb_rsp_paddr), .tlb_rsp_wr_ok(tlb_rsp_wr_ok),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_perm_rd(rsp_perm_rd),
    .rsp_perm_wr(rsp_perm_wr), .rsp_fault(rsp_fault), .rsp_exc(rsp_exc),
    .rsp_refill(rsp_refill), .badaddr_out(badaddr_out),
    .context_out(context_out), .entry_hi_out(entry_hi_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference: 0 direct, 1 lookup, 2 refused
  function automatic int classify(input logic [31:0] a, input logic [1:0] m,
                                  input bit erl, output logic [31:0] pa);
    int top3;
    bit k, s;
    top3 = int'(a >> 29);
    k = (m == 2'd0);
    s = (m == 2'd1);
    pa = 32'h0;
    if (top3 <= 3) begin
      pa = a;
      return erl ? 0 : 1;
    end
    if (top3 == 4 || top3 == 5) begin
      pa = a & 32'h1FFF_FFFF;
      return k ? 0 : 2;
    end
    if (top3 == 6) return (k || s) ? 1 : 2;
    return k ? 1 : 2;
  endfunction

  task automatic do_req(input string tag, input logic [31:0] a, input bit wr,
                        input logic [1:0] m, input bit erl,
                        input logic [31:0] ehi, input logic [31:0] ctx,
                        input logic [1:0] kind, input logic [31:0] tpa,
                        input bit wok, input int delay, input bit intrude);
    logic [31:0] epa, ebad, ectx, eehi;
    int cls, eexc;
    bit efault, erefill, erd, ewr;
    cls = classify(a, m, erl, epa);
    eexc = 0;
    erefill = 0;
    if (cls == 2) eexc = wr ? 2 : 1;
    else if (cls == 1) begin
      if (kind == 2'd1) begin eexc = wr ? 4 : 3; erefill = 1; end
      else if (kind == 2'd2) eexc = wr ? 4 : 3;
      else if (kind == 2'd3) eexc = 5;
    end
    efault = (eexc != 0);
    if (cls == 1 && !efault) epa = tpa;
    if (efault) epa = 0;
    erd = !efault;
    ewr = !efault && ((cls == 1) ? wok : 1'b1);
    ebad = efault ? a : 32'h0;
    ectx = efault ? ((ctx & ~32'h007F_FFF0) | ((a >> 9) & 32'h007F_FFF0)) : ctx;
    eehi = efault ? ((ehi & 32'h0000_00FF) | (a & 32'hFFFF_E000)) : ehi;

    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = wr; req_mode = m;
    err_level = erl; entry_hi_in = ehi; context_in = ctx;
    #1;
    chk(tlb_req_valid == (cls == 1), {tag, " R10 lookup strobe"}, 32'(tlb_req_valid), 32'(cls == 1));
    if (cls == 1) chk(tlb_req_addr == a, {tag, " R4 lookup addr"}, tlb_req_addr, a);
    @(negedge clk);
    req_valid = 0;
    if (cls == 1) begin
      chk(rsp_valid == 0, {tag, " R10 no early rsp"}, 32'(rsp_valid), 0);
      for (int i = 0; i < delay; i++) begin
        if (intrude && i == 0) begin
          req_valid = 1; req_addr = 32'h8000_0040; req_mode = 2'd0;
          req_write = !wr; entry_hi_in = 32'h5555_5555; context_in = 32'hAAAA_AAAA;
          #1;
          chk(tlb_req_valid == 0, {tag, " R10 ignored req no lookup"}, 32'(tlb_req_valid), 0);
        end
        @(negedge clk);
        req_valid = 0;
        chk(rsp_valid == 0, {tag, " R10 waiting"}, 32'(rsp_valid), 0);
      end
      tlb_rsp_valid = 1; tlb_rsp_kind = kind; tlb_rsp_paddr = tpa; tlb_rsp_wr_ok = wok;
      @(negedge clk);
      tlb_rsp_valid = 0;
    end
    chk(rsp_valid == 1, {tag, " R10 rsp strobe"}, 32'(rsp_valid), 1);
    chk(rsp_fault == efault, {tag, " R5 fault"}, 32'(rsp_fault), 32'(efault));
    chk(rsp_exc == 3'(eexc), {tag, " R6 exc"}, 32'(rsp_exc), 32'(eexc));
    chk(rsp_refill == erefill, {tag, " R6 refill"}, 32'(rsp_refill), 32'(erefill));
    chk(rsp_paddr == epa, {tag, " R7 paddr"}, rsp_paddr, epa);
    chk(rsp_perm_rd == erd, {tag, " R7 perm rd"}, 32'(rsp_perm_rd), 32'(erd));
    chk(rsp_perm_wr == ewr, {tag, " R7 perm wr"}, 32'(rsp_perm_wr), 32'(ewr));
    chk(badaddr_out == ebad, {tag, " R8 badaddr"}, badaddr_out, ebad);
    chk(context_out == ectx, {tag, " R8 R9 context"}, context_out, ectx);
    chk(entry_hi_out == eehi, {tag, " R8 R9 entry_hi"}, entry_hi_out, eehi);
    @(negedge clk);
    chk(rsp_valid == 0, {tag, " R10 single pulse"}, 32'(rsp_valid), 0);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rsp_valid == 0, "reset rsp_valid R10", 32'(rsp_valid), 0);
    chk(tlb_req_valid == 0, "reset tlb_req_valid R10", 32'(tlb_req_valid), 0);
    rst_n = 1;
    @(negedge clk);

    // R1 user segment
    do_req("R1 erl identity", 32'h1234_5678, 0, 2'd2, 1, 32'h0000_0042, 32'hFF80_000F, 0, 0, 0, 0, 0);
    do_req("R1 top edge", 32'h7FFF_FFFF, 1, 2'd0, 1, 32'h0000_0001, 32'h0, 0, 0, 0, 0, 0);
    do_req("R1 R7 lookup hit", 32'h0040_3000, 1, 2'd2, 0, 32'h0000_0011, 32'h1234_5670, 2'd0, 32'h0ABC_D000, 1, 2, 0);
    // R2 / R3 direct kernel segments
    do_req("R2 kseg0", 32'h8123_4567, 0, 2'd0, 0, 32'h0, 32'h0, 0, 0, 0, 0, 0);
    do_req("R2 kseg0 end", 32'h9FFF_FFFF, 1, 2'd0, 0, 32'h0, 32'h0, 0, 0, 0, 0, 0);
    do_req("R3 kseg1", 32'hBFC0_0010, 0, 2'd0, 0, 32'h0, 32'h0, 0, 0, 0, 0, 0);
    do_req("R3 kseg1 start", 32'hA000_0000, 1, 2'd0, 1, 32'h0, 32'h0, 0, 0, 0, 0, 0);
    // R5 refusals
    do_req("R5 user kseg0 read", 32'h8000_1000, 0, 2'd2, 0, 32'hDEAD_BEEF, 32'hCAFE_F00D, 0, 0, 0, 0, 0);
    do_req("R5 sup kseg1 write", 32'hB234_5678, 1, 2'd1, 0, 32'h1111_11A5, 32'h8765_4321, 0, 0, 0, 0, 0);
    do_req("R4 mode3 is user", 32'h8800_0000, 0, 2'd3, 0, 32'h0, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    // R4 mapped kernel/supervisor segments
    do_req("R4 R7 sup sseg hit ro", 32'hC000_1000, 0, 2'd1, 0, 32'h22, 32'h0, 2'd0, 32'h0100_0000, 0, 1, 0);
    do_req("R4 user sseg write", 32'hDFFF_FFFF, 1, 2'd2, 0, 32'h33, 32'h0, 0, 0, 0, 0, 0);
    do_req("R4 sup kseg3 read", 32'hE000_0000, 0, 2'd1, 0, 32'h44, 32'h0, 0, 0, 0, 0, 0);
    do_req("R4 R6 kern kseg3 nomatch", 32'hFFFF_FFFF, 1, 2'd0, 0, 32'h0000_0077, 32'h0, 2'd1, 0, 0, 0, 0);
    // R6 lookup failures
    do_req("R6 nomatch load", 32'h0123_6000, 0, 2'd2, 0, 32'hFFFF_FF99, 32'h8000_0005, 2'd1, 0, 0, 1, 0);
    do_req("R6 invalid store", 32'h0456_7000, 1, 2'd0, 0, 32'h0000_1F0C, 32'h0, 2'd2, 0, 0, 3, 0);
    do_req("R6 invalid load", 32'hC456_7ABC, 0, 2'd0, 0, 32'h0, 32'h7FFF_FFFF, 2'd2, 0, 0, 0, 0);
    do_req("R6 modify", 32'h0789_A000, 1, 2'd2, 0, 32'h0000_00EE, 32'h0, 2'd3, 0, 0, 1, 0);
    // R10 intruding request during a pending lookup
    do_req("R10 R9 intrude hit", 32'h0000_4000, 0, 2'd2, 0, 32'h0000_0123, 32'h0F0F_0F0F, 2'd0, 32'h0002_0000, 1, 3, 1);
    do_req("R10 R8 intrude fault", 32'h0ABC_E000, 1, 2'd1, 0, 32'h0000_0ABC, 32'h0F0F_0F0F, 2'd1, 0, 0, 2, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule